// File: doc/BRIEF.md
# SMT Thread Mode Controller

This block follows the activity of a processor core that runs two logical threads on one set of shared hardware. Each thread can report that it has executed a halt instruction, and each thread can be the target of an interrupt. Both arrive as single-cycle pulses. From these events the controller keeps one activity flag per thread. It reports the resulting core mode: both threads running, only thread 0 running, only thread 1 running, or nothing running (low power).

Halting one thread while both run leaves the other thread alone on the core. Halting that thread as well puts the core to sleep. An interrupt brings the thread it targets back into service. In low power, that thread resumes by itself. In a single-thread mode, the core returns to dual operation. Whenever exactly one thread runs, the block raises a recombine signal. This tells the queues that are split between the threads during dual operation to merge for the single thread.

Top module: `smt_mode_ctrl`

## Requirements
- R1: After reset, and while reset is held, the mode output is 0. The mode codes are: 0 both threads running, 1 only thread 0 running, 2 only thread 1 running, 3 low power. Reset overrides any pulse applied with it.
- R2: In mode 0, a halt pulse from only thread 1 (halt bit 1) gives mode 1 on the next cycle. A halt pulse from only thread 0 (halt bit 0) gives mode 2 on the next cycle.
- R3: In mode 0, halt pulses from both threads in the same cycle give mode 3 on the next cycle.
- R4: In mode 1, a halt from thread 0 gives mode 3, provided no interrupt for thread 1 arrives in that cycle. In mode 2, a halt from thread 1 gives mode 3 under the same condition for thread 0.
- R5: In mode 1, an interrupt for thread 1 (irq bit 1) gives mode 0 on the next cycle. In mode 2, an interrupt for thread 0 (irq bit 0) gives mode 0 on the next cycle. Both cases assume the running thread does not halt in that cycle.
- R6: In mode 3, an interrupt for thread 0 alone gives mode 1, an interrupt for thread 1 alone gives mode 2, and interrupts for both threads give mode 0.
- R7: A halt pulse from a thread that is already halted has no effect on the mode. An interrupt for a thread that is running has no effect on the mode. A cycle with no pulses leaves the mode unchanged.
- R8: Each thread is handled on its own in the same cycle. A running thread that sees both a halt and an interrupt halts. A halted thread that sees an interrupt resumes, even while the other thread halts.
- R9: The recombine output is 1 exactly when the mode is 1 or 2, and 0 in modes 0 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_pulse | input | 2 | Per-thread halt-executed pulse, bit t for thread t |
| irq_pulse | input | 2 | Per-thread interrupt pulse, bit t for thread t |
| mode | output | 2 | Current core mode, codes as in R1 |
| recombine | output | 1 | High while one thread owns all partitioned resources |

## Verification
Every pulse is sampled on a rising edge. The mode and recombine outputs take their new value directly after that same edge, so each result is due one cycle after its stimulus and stays until the next pulse. The bench drives pulses on the falling edge and holds them for one cycle. It checks mode and recombine on the following falling edge, half a cycle after the edge that took the pulse. The reset checks follow the same rule: the mode is read one falling edge after the first edge with reset high.

// File: rtl/smt_mode_pkg.sv
package smt_mode_pkg;

    localparam int NUM_THREADS = 2;
    localparam int MODE_W      = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_DUAL  = 2'd0,
        MODE_SOLO0 = 2'd1,
        MODE_SOLO1 = 2'd2,
        MODE_SLEEP = 2'd3
    } core_mode_t;

    typedef logic [NUM_THREADS-1:0] thread_vec_t;

    function automatic core_mode_t mode_of(thread_vec_t running);
        core_mode_t m;
        case (running)
            2'b11:   m = MODE_DUAL;
            2'b01:   m = MODE_SOLO0;
            2'b10:   m = MODE_SOLO1;
            default: m = MODE_SLEEP;
        endcase
        return m;
    endfunction

    function automatic logic single_owner(core_mode_t m);
        return (m == MODE_SOLO0) || (m == MODE_SOLO1);
    endfunction

endpackage

// File: rtl/smt_thread_slot.sv
module smt_thread_slot (
    input  logic clk,
    input  logic rst,
    input  logic halt_in,
    input  logic wake_in,
    output logic running
);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b1;
        end else if (running && halt_in) begin
            running <= 1'b0;
        end else if (!running && wake_in) begin
            running <= 1'b1;
        end
    end

endmodule

// File: rtl/smt_mode_encode.sv
module smt_mode_encode
    import smt_mode_pkg::*;
(
    input  thread_vec_t running,
    output core_mode_t  mode,
    output logic        recombine
);

    always_comb begin
        mode      = mode_of(running);
        recombine = single_owner(mode);
    end

endmodule

// File: rtl/smt_mode_ctrl.sv
module smt_mode_ctrl
    import smt_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] halt_pulse,
    input  logic [1:0] irq_pulse,
    output logic [1:0] mode,
    output logic       recombine
);

    thread_vec_t running;
    core_mode_t  mode_q;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        smt_thread_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .halt_in (halt_pulse[t]),
            .wake_in (irq_pulse[t]),
            .running (running[t])
        );
    end

    smt_mode_encode u_encode (
        .running   (running),
        .mode      (mode_q),
        .recombine (recombine)
    );

    assign mode = mode_q;

endmodule

// File: rtl/smt_mode_ctrl_chk.sv
module smt_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] halt_pulse,
    input logic [1:0] irq_pulse,
    input logic [1:0] mode,
    input logic       recombine
);

    // R1
    reset_dual_chk: assert property (@(posedge clk) rst |=> mode == 2'd0);

    // R2
    dual_to_solo0_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && halt_pulse == 2'b10) |=> mode == 2'd1);

    // R2
    dual_to_solo1_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && halt_pulse == 2'b01) |=> mode == 2'd2);

    // R3
    dual_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && halt_pulse == 2'b11) |=> mode == 2'd3);

    // R4
    solo0_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && halt_pulse[0] && !irq_pulse[1]) |=> mode == 2'd3);

    // R5
    solo0_to_dual_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && irq_pulse[1] && !halt_pulse[0]) |=> mode == 2'd0);

    // R6
    sleep_wake0_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && irq_pulse == 2'b01) |=> mode == 2'd1);

    // R7
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_pulse == 2'b00 && irq_pulse == 2'b00) |=> $stable(mode));

    // R9
    recombine_solo_chk: assert property (@(posedge clk) disable iff (rst)
        recombine |-> (mode != 2'd0 && mode != 2'd3));

    // R9
    solo_recombine_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 || mode == 2'd2) |-> recombine);

endmodule

bind smt_mode_ctrl smt_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_pulse (halt_pulse),
    .irq_pulse  (irq_pulse),
    .mode       (mode),
    .recombine  (recombine)
);

// File: tb/test_smt_mode_ctrl.sv
`timescale 1ns/1ps
module test_smt_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] halt_pulse;
    logic [1:0] irq_pulse;
    logic [1:0] mode;
    logic       recombine;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    smt_mode_ctrl i_smt_mode_ctrl (
        .clk        (clk),
        .rst        (rst),
        .halt_pulse (halt_pulse),
        .irq_pulse  (irq_pulse),
        .mode       (mode),
        .recombine  (recombine)
    );

    // fields: req[10:7] halt[6:5] irq[4:3] mode[2:1] recombine[0]
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        {4'd2, 2'b10, 2'b00, 2'd1, 1'b1},  // R2 dual, thread 1 halts
        {4'd5, 2'b00, 2'b10, 2'd0, 1'b0},  // R5 wake thread 1
        {4'd2, 2'b01, 2'b00, 2'd2, 1'b1},  // R2 dual, thread 0 halts
        {4'd4, 2'b10, 2'b00, 2'd3, 1'b0},  // R4 solo1 halts
        {4'd6, 2'b00, 2'b10, 2'd2, 1'b1},  // R6 sleep, wake thread 1
        {4'd5, 2'b00, 2'b01, 2'd0, 1'b0},  // R5 wake thread 0
        {4'd7, 2'b00, 2'b11, 2'd0, 1'b0},  // R7 irq to running threads
        {4'd3, 2'b11, 2'b00, 2'd3, 1'b0},  // R3 both halt together
        {4'd6, 2'b00, 2'b01, 2'd1, 1'b1},  // R6 sleep, wake thread 0
        {4'd7, 2'b10, 2'b00, 2'd1, 1'b1},  // R7 halted thread halts again
        {4'd7, 2'b00, 2'b01, 2'd1, 1'b1},  // R7 irq to running thread
        {4'd8, 2'b01, 2'b10, 2'd2, 1'b1},  // R8 swap: t0 halts, t1 wakes
        {4'd8, 2'b10, 2'b10, 2'd3, 1'b0},  // R8 halt beats irq
        {4'd6, 2'b00, 2'b11, 2'd0, 1'b0},  // R6 wake both
        {4'd8, 2'b01, 2'b01, 2'd2, 1'b1},  // R8 halt beats irq, thread 0
        {4'd7, 2'b00, 2'b00, 2'd2, 1'b1},  // R7 quiet cycle
        {4'd4, 2'b10, 2'b00, 2'd3, 1'b0},  // R4 solo1 to sleep
        {4'd7, 2'b11, 2'b00, 2'd3, 1'b0},  // R7 halts while asleep
        {4'd6, 2'b00, 2'b01, 2'd1, 1'b1},  // R6 wake thread 0
        {4'd4, 2'b01, 2'b00, 2'd3, 1'b0},  // R4 solo0 to sleep
        {4'd9, 2'b00, 2'b00, 2'd3, 1'b0}   // R9 recombine low asleep
    };

    task automatic check(input int req, input logic [1:0] exp_mode, input logic exp_rc);
        checks++;
        if (mode !== exp_mode || recombine !== exp_rc) begin
            errors++;
            $display("FAIL R%0d: mode=%0d recombine=%0b expected mode=%0d recombine=%0b",
                     req, mode, recombine, exp_mode, exp_rc);
        end
    endtask

    task automatic step(input logic [1:0] h, input logic [1:0] i);
        @(negedge clk);
        halt_pulse = h;
        irq_pulse  = i;
        @(negedge clk);
        halt_pulse = 2'b00;
        irq_pulse  = 2'b00;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        halt_pulse = 2'b00;
        irq_pulse  = 2'b00;
        repeat (3) @(negedge clk);
        check(1, 2'd0, 1'b0);  // R1 reset state
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][6:5], VEC[k][4:3]);
            check(int'(VEC[k][10:7]), VEC[k][2:1], VEC[k][0]);
        end

        // R1 reset from low power with pulses present
        @(negedge clk);
        rst        = 1'b1;
        halt_pulse = 2'b11;
        irq_pulse  = 2'b01;
        @(negedge clk);
        check(1, 2'd0, 1'b0);
        halt_pulse = 2'b00;
        irq_pulse  = 2'b00;
        rst        = 1'b0;

        // R1 reset from a single-thread mode
        step(2'b01, 2'b00);
        check(2, 2'd2, 1'b1);   // R2
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(1, 2'd0, 1'b0);

        // R9 recombine after reset release stays low
        @(negedge clk);
        check(9, 2'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule